// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block sits on a simple byte-wide register bus and manages an array of one-time-programmable fuses organised as banks of byte-wide words. Software points two address registers at one fuse bit, then starts either a program cycle, which blows that single bit, or a sense cycle, which copies the whole addressed word from the fuse array into a sense data register. Each cycle holds a busy flag for a fixed number of clocks, then raises a done flag or an error flag. The array itself is a synthesizable register model; each bank carries fixed protect bits that block reads, programming or overrides.

Alongside the fuse array the block keeps a shadow copy of every word. A read of the bank window returns the shadow. A write to the bank window overrides the shadow and leaves the fuses alone. Programming a bit sets it in both copies. Status and error flags are write-one-to-clear. A level interrupt is raised when any flag is set whose mask bit is also set.

Top module: `fuse_ctrl`

## Requirements
- R1: Register offsets: 0 status, 1 error, 2 status mask, 3 error mask, 4 control, 5 address high, 6 address low, 7 sense data, 8 program key. Address bit 11 set selects the bank window, with the bank in bits 10:8 and the word in bits 7:0. The target word is {high[2:0], low[7:3]}, the bank is high[5:3] and the bit is low[2:0].
- R2: A successful program cycle sets only the addressed bit, in both the fuse word and its shadow. Bits already set stay set.
- R3: A program cycle started while the key register differs from 0xAA sets error bit 7, leaves the status done flags clear and changes no fuse.
- R4: A program cycle to a write-protected bank (bank 7 by default), with the key correct, sets error bit 6 and changes no fuse.
- R5: A control write with bit 0 set starts a program cycle that lasts PROG_CYC clocks (default 16). A control write with bit 3 set starts a sense cycle that lasts SNS_CYC clocks (default 4). Bit 0 wins if both are set. Status bit 7 reads 1 while a cycle runs. On success, status bit 1 (program) or bit 0 (sense) sets when the cycle ends.
- R6: Control bits 7:4 are stored and read back with bits 3:0 as zero. Any control write made while busy is ignored.
- R7: A successful sense cycle loads the addressed fuse word, not its shadow, into sense data. A sense of a read-protected bank (bank 6 by default) sets error bit 2, sets no done flag and leaves sense data unchanged.
- R8: A bank-window read returns the shadow word. A read of a read-protected bank returns 0x00 and sets error bit 4.
- R9: A bank-window write replaces the shadow word. In an override-protected bank (bank 5 by default) the write is dropped and error bit 5 sets.
- R10: Writing 1 to a status or error bit clears that bit. Writing 0 leaves it unchanged. A flag set in the same cycle as a clear stays set.
- R11: irq is 1 exactly when a status done bit is set with its status mask bit set, or an error bit is set with its error mask bit set.
- R12: Every read request is answered with rsp_valid high on the clock that follows it. No other clock raises rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 12 | Register offset or bank-window address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, one clock after a read |
| rsp_rdata | output | 8 | Read data |
| irq | output | 1 | Masked flag interrupt |

## Verification
On every clock the assertions check four things: a busy period never runs longer than the program length, a done flag only appears on the clock busy drops, control bits and sense data stay frozen outside their update windows, and read responses follow the request timing. Some behaviour can only be shown by the bench's scenarios. This covers the value that lands in a fuse word, the protect and key rejections, the difference between fuse and shadow contents, and the clearing of flags by write-one-to-clear.

// File: rtl/fuse_ctrl.sv
module fuse_ctrl #(
  parameter int BANKS = 8,
  parameter int WORDS = 256,
  parameter int PROG_CYC = 16,
  parameter int SNS_CYC = 4,
  parameter logic [7:0] KEY = 8'hAA,
  parameter logic [BANKS-1:0] RD_PROT = 8'h40,
  parameter logic [BANKS-1:0] WR_PROT = 8'h80,
  parameter logic [BANKS-1:0] OV_PROT = 8'h20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [11:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        rsp_valid,
  output logic [7:0]  rsp_rdata,
  output logic        irq
);
  localparam int DEPTH = BANKS * WORDS;
  localparam int IW = $clog2(DEPTH);
  localparam int LONG = (PROG_CYC > SNS_CYC) ? PROG_CYC : SNS_CYC;
  localparam int CW = $clog2(LONG + 1);

  logic [7:0] fuse_q [DEPTH];
  logic [7:0] shad_q [DEPTH];
  logic [5:0] hi_q;
  logic [7:0] lo_q, key_q, sdat_q, err_q, emask_q;
  logic [1:0] done_q, smask_q;
  logic [3:0] ctl_q;
  logic       busy_q, prog_q, keyok_q;
  logic [CW-1:0] cnt_q;
  logic [2:0] tbank_q, tbit_q;
  logic [7:0] trow_q;

  wire wr = req_valid & req_write;
  wire rd = req_valid & ~req_write;
  wire win = req_addr[11];
  wire [2:0] wbank = req_addr[10:8];
  wire [7:0] wrow = req_addr[7:0];
  wire win_ok = (32'(wbank) < BANKS) && (32'(wrow) < WORDS);
  wire [IW-1:0] widx = IW'(int'(wbank) * WORDS + int'(wrow));
  wire reg_sel = ~win && (req_addr[10:4] == 7'd0);
  wire [3:0] off = req_addr[3:0];

  wire t_ok = (32'(tbank_q) < BANKS) && (32'(trow_q) < WORDS);
  wire [IW-1:0] tidx = IW'(int'(tbank_q) * WORDS + int'(trow_q));
  wire fin = busy_q && (cnt_q == '0);
  wire ctl_wr = wr && reg_sel && off == 4'd4 && !busy_q;
  wire start = ctl_wr && (req_wdata[0] | req_wdata[3]);

  logic [7:0] err_set, err_clr, rd_mux;
  logic [1:0] done_set, done_clr;

  always_comb begin
    err_set = '0;
    done_set = '0;
    if (fin) begin
      if (prog_q) begin
        if (!keyok_q) err_set[7] = 1'b1;
        else if (WR_PROT[tbank_q] || !t_ok) err_set[6] = 1'b1;
        else done_set[1] = 1'b1;
      end else begin
        if (RD_PROT[tbank_q] || !t_ok) err_set[2] = 1'b1;
        else done_set[0] = 1'b1;
      end
    end
    if (rd && win && (!win_ok || RD_PROT[wbank])) err_set[4] = 1'b1;
    if (wr && win && (!win_ok || OV_PROT[wbank])) err_set[5] = 1'b1;
    done_clr = (wr && reg_sel && off == 4'd0) ? req_wdata[1:0] : 2'b00;
    err_clr  = (wr && reg_sel && off == 4'd1) ? req_wdata : 8'h00;
  end

  always_comb begin
    rd_mux = 8'h00;
    if (win) begin
      if (win_ok && !RD_PROT[wbank]) rd_mux = shad_q[widx];
    end else if (reg_sel) begin
      case (off)
        4'd0: rd_mux = {busy_q, 5'b0, done_q};
        4'd1: rd_mux = err_q;
        4'd2: rd_mux = {6'b0, smask_q};
        4'd3: rd_mux = emask_q;
        4'd4: rd_mux = {ctl_q, 4'b0};
        4'd5: rd_mux = {2'b0, hi_q};
        4'd6: rd_mux = lo_q;
        4'd7: rd_mux = sdat_q;
        4'd8: rd_mux = key_q;
        default: rd_mux = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        fuse_q[i] <= 8'h00;
        shad_q[i] <= 8'h00;
      end
      hi_q <= '0; lo_q <= '0; key_q <= '0; sdat_q <= '0;
      err_q <= '0; emask_q <= '0; done_q <= '0; smask_q <= '0;
      ctl_q <= '0; busy_q <= 1'b0; prog_q <= 1'b0; keyok_q <= 1'b0;
      cnt_q <= '0; tbank_q <= '0; tbit_q <= '0; trow_q <= '0;
      rsp_valid <= 1'b0; rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_mux;
      done_q <= (done_q & ~done_clr) | done_set;
      err_q  <= (err_q & ~err_clr) | err_set;
      if (wr && reg_sel) begin
        case (off)
          4'd2: smask_q <= req_wdata[1:0];
          4'd3: emask_q <= req_wdata;
          4'd5: hi_q <= req_wdata[5:0];
          4'd6: lo_q <= req_wdata;
          4'd8: key_q <= req_wdata;
          default: ;
        endcase
      end
      if (ctl_wr) ctl_q <= req_wdata[7:4];
      if (start) begin
        busy_q  <= 1'b1;
        prog_q  <= req_wdata[0];
        keyok_q <= (key_q == KEY);
        cnt_q   <= req_wdata[0] ? CW'(PROG_CYC - 1) : CW'(SNS_CYC - 1);
        tbank_q <= hi_q[5:3];
        trow_q  <= {hi_q[2:0], lo_q[7:3]};
        tbit_q  <= lo_q[2:0];
      end else if (fin) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (done_set[1]) begin
        fuse_q[tidx] <= fuse_q[tidx] | (8'd1 << tbit_q);
        shad_q[tidx] <= shad_q[tidx] | (8'd1 << tbit_q);
      end
      if (done_set[0]) sdat_q <= fuse_q[tidx];
      if (wr && win && win_ok && !OV_PROT[wbank]) shad_q[widx] <= req_wdata;
    end
  end

  assign irq = |(done_q & smask_q) | |(err_q & emask_q);
endmodule

// File: rtl/fuse_ctrl_chk.sv
module fuse_ctrl_chk #(
  parameter int PROG_CYC = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_write,
  input logic       rsp_valid,
  input logic       busy,
  input logic [1:0] done,
  input logic [3:0] ctl_hi,
  input logic [7:0] sdat
);
  int blen;
  always_ff @(posedge clk) begin
    if (!rst_n) blen <= 0;
    else if (busy) blen <= blen + 1;
    else blen <= 0;
  end

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> blen < PROG_CYC);

  // R5
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((done & ~$past(done)) != 2'b00) |-> $fell(busy));

  // R6
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ctl_hi));

  // R7
  sdat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> $stable(sdat));

  // R12
  rsp_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  // R12
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
endmodule

bind fuse_ctrl fuse_ctrl_chk #(.PROG_CYC(PROG_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .busy(busy_q), .done(done_q), .ctl_hi(ctl_q),
  .sdat(sdat_q)
);

// File: tb/fuse_ctrl_tb_top.sv
`timescale 1ns/1ps
module fuse_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic rsp_valid, irq;
  logic [7:0] rsp_rdata;

  always #2 clk = ~clk;

  fuse_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .irq(irq)
  );

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb[$];
  int checks = 0, errors = 0;

  localparam logic [11:0] STAT = 12'h000, ERR = 12'h001, SMASK = 12'h002,
    EMASK = 12'h003, CTL = 12'h004, AHI = 12'h005, ALO = 12'h006,
    SDAT = 12'h007, KEYR = 12'h008;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) chk("R12 unexpected response", 8'h01, 8'h00);
      else begin
        item_t it;
        it = sb.pop_front();
        chk(it.tag, rsp_rdata, it.exp);
      end
    end
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    rd(STAT, 8'h00, "R5 reset status");
    rd(ERR, 8'h00, "R10 reset error");
    chk("R11 reset irq", {7'b0, irq}, 8'h00);

    // R1/R2: bank 2, word 0xA5, bit 5
    wr(SMASK, 8'h02);
    wr(KEYR, 8'hAA);
    wr(AHI, 8'h15);
    wr(ALO, 8'h2D);
    wr(CTL, 8'h01);
    rd(STAT, 8'h80, "R5 busy during program");
    idle(20);
    chk("R11 irq on masked done", {7'b0, irq}, 8'h01);
    rd(STAT, 8'h02, "R5 program done");
    rd(12'hAA5, 8'h20, "R2 R1 shadow after program");
    wr(STAT, 8'h02);
    rd(STAT, 8'h00, "R10 done cleared");
    chk("R11 irq after clear", {7'b0, irq}, 8'h00);

    // R2: second bit in same word
    wr(ALO, 8'h28);
    wr(CTL, 8'h01);
    idle(20);
    rd(12'hAA5, 8'h21, "R2 bits accumulate");
    wr(STAT, 8'h03);

    // R7: sense same word
    wr(CTL, 8'h08);
    idle(8);
    rd(STAT, 8'h01, "R7 sense done");
    rd(SDAT, 8'h21, "R7 R1 sense data");
    wr(STAT, 8'h01);

    // R3: no key
    wr(KEYR, 8'h00);
    wr(ALO, 8'h2A);
    wr(CTL, 8'h01);
    idle(20);
    rd(ERR, 8'h80, "R3 program error");
    rd(STAT, 8'h00, "R3 no done");
    rd(12'hAA5, 8'h21, "R3 fuse unchanged");
    wr(ERR, 8'h80);
    rd(ERR, 8'h00, "R10 error cleared");

    // R4: write-protected bank 7
    wr(KEYR, 8'hAA);
    wr(AHI, 8'h38);
    wr(ALO, 8'h00);
    wr(CTL, 8'h01);
    idle(20);
    rd(ERR, 8'h40, "R4 write protect error");
    rd(12'hF00, 8'h00, "R4 protected word unchanged");
    wr(ERR, 8'hFF);

    // R9/R7: override bank 3 word 5, fuse stays 0
    wr(12'hB05, 8'h5A);
    rd(12'hB05, 8'h5A, "R9 override shadow");
    wr(AHI, 8'h18);
    wr(ALO, 8'h28);
    wr(CTL, 8'h08);
    idle(8);
    rd(SDAT, 8'h00, "R7 sense reads fuse not shadow");
    wr(STAT, 8'hFF);

    // R9: override-protected bank 5
    wr(12'hD10, 8'h33);
    rd(ERR, 8'h20, "R9 override protect error");
    rd(12'hD10, 8'h00, "R9 protected shadow unchanged");
    wr(ERR, 8'hFF);

    // R8/R7: read-protected bank 6
    rd(12'hE00, 8'h00, "R8 protected read returns zero");
    rd(ERR, 8'h10, "R8 read protect error");
    wr(ERR, 8'hFF);
    wr(AHI, 8'h30);
    wr(ALO, 8'h00);
    wr(CTL, 8'h08);
    idle(8);
    rd(ERR, 8'h04, "R7 sense error");
    rd(STAT, 8'h00, "R7 no sense done");
    rd(SDAT, 8'h00, "R7 sense data kept");
    wr(ERR, 8'hFF);

    // R6: control write while busy ignored
    wr(AHI, 8'h08);
    wr(ALO, 8'h00);
    wr(CTL, 8'h58);
    wr(CTL, 8'h31);
    idle(20);
    rd(STAT, 8'h01, "R6 only sense completed");
    rd(12'h900, 8'h00, "R6 no program while busy");
    rd(CTL, 8'h50, "R6 control readback");
    wr(STAT, 8'hFF);

    // R11: error mask
    wr(EMASK, 8'h20);
    wr(12'hD00, 8'h11);
    chk("R11 irq on masked error", {7'b0, irq}, 8'h01);

    idle(4);
    chk("R12 all reads answered", 8'(sb.size()), 8'h00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule